// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that sits in memory. A base register input gives the physical start of the current process's directory. The upper ten address bits pick a directory entry. That entry names the frame that holds the second-level table. The next ten bits pick an entry in that table, and the low twelve bits are the byte offset inside a 4 KB page.

The walker takes one request at a time through a valid/ready handshake. It reads the directory entry and then the table entry through a simple memory port that allows one access in flight. It then judges the access against the entry bits. It finishes with a one-cycle done pulse that carries either a translated address or a fault code. When a permitted write reaches a page whose dirty bit is clear, the walker first writes the table entry back with that bit set, and only then signals completion.

Both levels use the same entry layout. Bit 0 is present. Bit 1 allows writes when set. Bit 2 allows user access when set. Bit 6 is dirty. Bits 10:9 give the page status: 00 unused, 01 committed, 10 reserved, 11 treated like committed. Bits 31:12 hold the frame number. Status and dirty are only examined in table entries.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read at dirBase + 4 × vaddr[31:22]. The table entry is read at {directory frame, 12'h000} + 4 × vaddr[21:12].
- R2: A successful translation returns fault code 0 and physAddr = {table entry bits 31:12, vaddr[11:0]}.
- R3: A directory entry with bit 0 clear ends the walk with fault code 1 (page fault) after exactly one memory read.
- R4: A table entry whose status bits 10:9 equal 00 gives fault code 3 (unused-page trap). This check has priority over the present bit.
- R5: A table entry with status other than 00 and bit 0 clear gives fault code 1 (page fault).
- R6: A present entry gives fault code 2 (protection fault) in two cases: a write where bit 1 is clear at either level, or a user access where bit 2 is clear at either level.
- R7: A permitted write to a table entry whose bit 6 is clear writes that entry back to the same address with bit 6 set, and does so before done. No other request writes memory.
- R8: reqReady is high only while the walker is idle. done is a single-cycle pulse. physAddr is zero whenever the fault code is nonzero.
- R9: Once memValid rises, memValid, memWrite and memAddr hold steady until the cycle in which memAck is seen.
- R10: After reset, reqReady is 1, and done and memValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirBase | input | 32 | Physical address of the current directory |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access comes from user privilege |
| done | output | 1 | One-cycle completion pulse |
| physAddr | output | 32 | Translated address, valid with done and fault 0 |
| fault | output | 2 | 0 none, 1 page fault, 2 protection, 3 unused trap |
| memValid | output | 1 | Memory access requested |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access complete; read data valid this cycle |
| memRdata | input | 32 | Read data |

## Verification
The hardest case to reach is the dirty write-back. It only occurs when a clean table entry is present, its status is not unused, and both levels allow the access. The write-back must also happen between the table read and done. The bench keeps a behavioural memory that counts reads and writes per request and records the addresses it serves. It arranges a clean, writable, user page, writes to it once, and checks three things: the stored entry afterwards, exactly one write before done, and no write on a second store to the same page. The whole vector table runs again with a slower memory, so that the address-hold rule is exercised over several wait cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PRESENT_BIT = 0;
  localparam int RW_BIT      = 1;
  localparam int USER_BIT    = 2;
  localparam int DIRTY_BIT   = 6;
  localparam int STAT_LO     = 9;

  typedef enum logic [1:0] {
    FAULT_NONE   = 2'd0,
    FAULT_PAGE   = 2'd1,
    FAULT_PROT   = 2'd2,
    FAULT_UNUSED = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_UNUSED  = 2'd0,
    ST_COMMIT  = 2'd1,
    ST_RESERVE = 2'd2,
    ST_SPARE   = 2'd3
  } status_e;

  typedef struct packed {
    logic   capReq;
    logic   capDir;
    logic   capPte;
    logic   setFault;
    fault_e faultCode;
    logic   selPte;
  } strobe_t;

  typedef struct packed {
    logic   dirPresent;
    fault_e pteFault;
    logic   needDirty;
  } verdict_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] memRdata,
  output verdict_t          verdict,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] resultAddr,
  output fault_e            resultFault
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  vaddrQ, baseQ, pteQ;
  logic               writeQ, userQ;
  logic [FRAME_W-1:0] dirFrameQ;
  logic               dirRwQ, dirUserQ;
  fault_e             faultQ;

  logic [IDX_W-1:0]   dirIdx, tblIdx;
  logic [OFF_W-1:0]   offset;
  logic [ADDR_W-1:0]  dirEntAddr, pteEntAddr;
  logic [1:0]         entStatus;
  logic               rdPresent, rdRw, rdUser;

  assign dirIdx = vaddrQ[ADDR_W-1 -: IDX_W];
  assign tblIdx = vaddrQ[OFF_W+IDX_W-1 : OFF_W];
  assign offset = vaddrQ[OFF_W-1:0];

  assign dirEntAddr = baseQ + ADDR_W'({dirIdx, 2'b00});
  assign pteEntAddr = {dirFrameQ, {OFF_W{1'b0}}} + ADDR_W'({tblIdx, 2'b00});
  assign memAddr    = strobe.selPte ? pteEntAddr : dirEntAddr;
  assign memWdata   = pteQ | (ADDR_W'(1) << DIRTY_BIT);

  assign entStatus = memRdata[STAT_LO+1:STAT_LO];
  assign rdPresent = memRdata[PRESENT_BIT];
  assign rdRw      = memRdata[RW_BIT];
  assign rdUser    = memRdata[USER_BIT];

  always_comb begin
    verdict.dirPresent = rdPresent;
    verdict.needDirty  = writeQ && !memRdata[DIRTY_BIT];
    if (entStatus == ST_UNUSED)
      verdict.pteFault = FAULT_UNUSED;
    else if (!rdPresent)
      verdict.pteFault = FAULT_PAGE;
    else if ((writeQ && !(dirRwQ && rdRw)) || (userQ && !(dirUserQ && rdUser)))
      verdict.pteFault = FAULT_PROT;
    else
      verdict.pteFault = FAULT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ    <= '0;
      baseQ     <= '0;
      writeQ    <= 1'b0;
      userQ     <= 1'b0;
      dirFrameQ <= '0;
      dirRwQ    <= 1'b0;
      dirUserQ  <= 1'b0;
      pteQ      <= '0;
      faultQ    <= FAULT_NONE;
    end else begin
      if (strobe.capReq) begin
        vaddrQ <= reqVaddr;
        baseQ  <= dirBase;
        writeQ <= reqWrite;
        userQ  <= reqUser;
      end
      if (strobe.capDir) begin
        dirFrameQ <= memRdata[ADDR_W-1:OFF_W];
        dirRwQ    <= rdRw;
        dirUserQ  <= rdUser;
      end
      if (strobe.capPte)   pteQ   <= memRdata;
      if (strobe.setFault) faultQ <= strobe.faultCode;
    end
  end

  assign resultFault = faultQ;
  assign resultAddr  = (faultQ == FAULT_NONE) ? {pteQ[ADDR_W-1:OFF_W], offset} : '0;
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memAck,
  input  verdict_t verdict,
  output logic     reqReady,
  output logic     done,
  output logic     memValid,
  output logic     memWrite,
  output strobe_t  strobe
);
  typedef enum logic [2:0] {S_IDLE, S_DIR, S_PTE, S_WB, S_DONE} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    strobe.faultCode = FAULT_NONE;
    strobe.selPte    = (state == S_PTE) || (state == S_WB);
    unique case (state)
      S_IDLE: if (reqValid) begin
        strobe.capReq = 1'b1;
        stateNext     = S_DIR;
      end
      S_DIR: if (memAck) begin
        if (!verdict.dirPresent) begin
          strobe.setFault  = 1'b1;
          strobe.faultCode = FAULT_PAGE;
          stateNext        = S_DONE;
        end else begin
          strobe.capDir = 1'b1;
          stateNext     = S_PTE;
        end
      end
      S_PTE: if (memAck) begin
        strobe.capPte = 1'b1;
        if (verdict.pteFault != FAULT_NONE) begin
          strobe.setFault  = 1'b1;
          strobe.faultCode = verdict.pteFault;
          stateNext        = S_DONE;
        end else if (verdict.needDirty) begin
          stateNext = S_WB;
        end else begin
          strobe.setFault = 1'b1;
          stateNext       = S_DONE;
        end
      end
      S_WB: if (memAck) begin
        strobe.setFault = 1'b1;
        stateNext       = S_DONE;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == S_IDLE);
  assign done     = (state == S_DONE);
  assign memValid = (state == S_DIR) || (state == S_PTE) || (state == S_WB);
  assign memWrite = (state == S_WB);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memValid && !done));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  output logic              done,
  output logic [ADDR_W-1:0] physAddr,
  output logic [1:0]        fault,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRdata
);
  strobe_t           strobe;
  verdict_t          verdict;
  logic [ADDR_W-1:0] resultAddr;
  fault_e            resultFault;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .verdict(verdict), .reqReady(reqReady), .done(done),
    .memValid(memValid), .memWrite(memWrite), .strobe(strobe)
  );

  ptw_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .dirBase(dirBase),
    .memRdata(memRdata), .verdict(verdict), .memAddr(memAddr),
    .memWdata(memWdata), .resultAddr(resultAddr), .resultFault(resultFault)
  );

  assign physAddr = done ? resultAddr : '0;
  assign fault    = done ? resultFault : FAULT_NONE;

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memAck) |=> (memValid && $stable(memAddr) && $stable(memWrite)));
  assert_fault_zero_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault != 2'd0) |-> (physAddr == '0));
  assert_wb_follows_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid && memWrite) |-> $past(memAck));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dirBase = 32'h0001_0000;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqUser = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqReady, done, memValid, memWrite;
  logic [31:0] physAddr, memAddr, memWdata;
  logic [1:0]  fault;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int checks = 0, fails = 0;
  int lat = 0, cnt = 0, nReads = 0, nWrites = 0;
  logic [31:0] rdAddr0 = '0, rdAddr1 = '0;
  logic [31:0] mem [logic [31:0]];

  always #2.5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rstN(rstN), .dirBase(dirBase), .reqValid(reqValid),
    .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .reqUser(reqUser), .done(done), .physAddr(physAddr), .fault(fault),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [31:0] rdMem(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      cnt = 0;
    end else if (memValid && !memAck) begin
      if (cnt >= lat) begin
        memAck <= 1'b1;
        cnt = 0;
        if (memWrite) begin
          mem[memAddr] = memWdata;
          nWrites++;
        end else begin
          memRdata <= rdMem(memAddr);
          if (nReads == 0) rdAddr0 <= memAddr; else rdAddr1 <= memAddr;
          nReads++;
        end
      end else cnt++;
    end else memAck <= 1'b0;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [1:0]  gotFault;
  logic [31:0] gotAddr;

  task automatic walk(logic [31:0] va, logic wr, logic usr);
    @(negedge clk);
    nReads = 0; nWrites = 0;
    reqVaddr = va; reqWrite = wr; reqUser = usr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R8 busy ready", {31'd0, reqReady}, 32'd0);
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      @(negedge clk);
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL R8 done: actual 0 expected 1");
    end
    gotFault = fault;
    gotAddr  = physAddr;
    @(negedge clk);
    check("R8 done pulse", {31'd0, done}, 32'd0);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic [1:0]  flt;
    logic [31:0] pa;
    logic [1:0]  reads;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{32'h0000_0000, 1'b0, 1'b0, 2'd1, 32'h0,          2'd1}, // R3 directory absent
    '{32'h0040_0000, 1'b0, 1'b1, 2'd3, 32'h0,          2'd2}, // R4 unused, present
    '{32'h0040_6000, 1'b0, 1'b1, 2'd3, 32'h0,          2'd2}, // R4 unused beats absent
    '{32'h0040_1000, 1'b0, 1'b1, 2'd1, 32'h0,          2'd2}, // R5 page absent
    '{32'h0040_2123, 1'b0, 1'b1, 2'd0, 32'hABCD_E123, 2'd2}, // R2 user read
    '{32'h0040_3000, 1'b1, 1'b1, 2'd2, 32'h0,          2'd2}, // R6 write read-only
    '{32'h0040_3FFF, 1'b0, 1'b1, 2'd0, 32'h1234_5FFF, 2'd2}, // R2 read read-only
    '{32'h0040_4000, 1'b0, 1'b1, 2'd2, 32'h0,          2'd2}, // R6 user on kernel page
    '{32'h0040_4000, 1'b0, 1'b0, 2'd0, 32'h5432_1000, 2'd2}, // R2 kernel read
    '{32'h0040_5010, 1'b1, 1'b1, 2'd0, 32'h0BEE_F010, 2'd2}, // R7 dirty already set
    '{32'h0080_0ABC, 1'b0, 1'b0, 2'd0, 32'h7777_7ABC, 2'd2}, // R2 second directory
    '{32'h0080_0ABC, 1'b1, 1'b0, 2'd2, 32'h0,          2'd2}, // R6 directory read-only
    '{32'h0080_0000, 1'b0, 1'b1, 2'd2, 32'h0,          2'd2}  // R6 directory kernel-only
  };

  task automatic loadTables();
    mem.delete();
    mem[32'h0001_0004] = 32'h0002_0207; // dir 1: rw, user
    mem[32'h0001_0008] = 32'h0003_0201; // dir 2: read-only, kernel
    mem[32'h0002_0000] = 32'h1111_1007;
    mem[32'h0002_0004] = 32'h0000_0206;
    mem[32'h0002_0008] = 32'hABCD_E207;
    mem[32'h0002_000C] = 32'h1234_5205;
    mem[32'h0002_0010] = 32'h5432_1203;
    mem[32'h0002_0014] = 32'h0BEE_F447;
    mem[32'h0002_0018] = 32'h0000_0006;
    mem[32'h0003_0000] = 32'h7777_7207;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    loadTables();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ready", {31'd0, reqReady}, 32'd1);
    check("R10 done", {31'd0, done}, 32'd0);
    check("R10 memValid", {31'd0, memValid}, 32'd0);
    rstN = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      lat = pass * 3;
      for (int k = 0; k < 13; k++) begin
        walk(VECS[k].va, VECS[k].wr, VECS[k].usr);
        check($sformatf("R2-R6 vec%0d fault", k), {30'd0, gotFault}, {30'd0, VECS[k].flt});
        check($sformatf("R2-R6 vec%0d addr", k), gotAddr, VECS[k].pa);
        check($sformatf("R3 vec%0d reads", k), nReads, {30'd0, VECS[k].reads});
        check($sformatf("R7 vec%0d writes", k), nWrites, 32'd0);
      end
    end

    // R1 entry addresses
    lat = 1;
    walk(32'h0040_2123, 1'b0, 1'b0);
    check("R1 dir entry addr", rdAddr0, 32'h0001_0004);
    check("R1 table entry addr", rdAddr1, 32'h0002_0008);

    // R7 dirty write-back on a clean writable page
    walk(32'h0040_2040, 1'b1, 1'b1);
    check("R7 fault", {30'd0, gotFault}, 32'd0);
    check("R7 addr", gotAddr, 32'hABCD_E040);
    check("R7 one write", nWrites, 32'd1);
    check("R7 stored entry", rdMem(32'h0002_0008), 32'hABCD_E247);
    walk(32'h0040_2044, 1'b1, 1'b1);
    check("R7 no second write", nWrites, 32'd0);
    check("R7 second addr", gotAddr, 32'hABCD_E044);

    // R7 faulting write leaves a clean page clean
    walk(32'h0040_3000, 1'b1, 1'b1);
    check("R7 fault write count", nWrites, 32'd0);
    check("R7 read-only entry", rdMem(32'h0002_000C), 32'h1234_5205);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule